// File: doc/BRIEF.md
# Dual Servo Pulse Generator

This block drives two hobby-servo control lines from one free-running frame counter. A prescaler divides the system clock by a power of two, and the frame counter runs from zero up to a programmable modulus and then wraps. Each output is high from counter zero until the counter reaches that channel's compare value. With the default sizing, the counter rate and modulus give a 20 ms frame (50 Hz). The pulse limits are set so that position -1 gives about 0.95 ms and position +1 gives about 1.60 ms.

Software gives a signed position command and selects a channel. The block maps the position linearly between two pulse-width limits, which are given in counter ticks. The result is written to a pending register for that channel. Pending values move into the live compares only when the frame wraps, so an output never changes in the middle of a pulse.

Each wrap does three things:
- It raises a one-cycle start pulse for a companion sensor-scan sequencer.
- It sets a sticky wrap flag, which software clears by writing a one.
- It advances a frame counter that saturates at its top value instead of wrapping.

Top module: `servo_pwm_pair`

## Requirements
- R1: After synchronous reset the frame counter is 0, both live and pending compares hold the position-0 mapping, `scan_start` and `wrap_flag` are 0, and `frame_count` is 0.
- R2: The frame counter advances once every 2^PRESC_LOG2 clocks. It counts 0 to `period_mod` inclusive and then returns to 0, so a frame lasts (`period_mod`+1)·2^PRESC_LOG2 clocks.
- R3: `pwm_out[i]` is high exactly while the frame counter is below live compare i. A compare of 0 keeps the line low for the whole frame, and a compare above `period_mod` keeps it high for the whole frame.
- R4: A position p (two's complement, POS_W bits, scale 2^(POS_W-1) = 1.0) maps to `width_min` + floor((p + 2^(POS_W-1))·(`width_max`−`width_min`) / 2^POS_W). The most negative p gives `width_min` exactly.
- R5: A write updates only the pending compare. The outputs keep their old live compare until the next wrap, when both pending values are committed together.
- R6: `scan_start` is high for exactly one clock, in the first clock after each wrap, when the frame counter reads 0.
- R7: `frame_count` increments by one at each wrap and holds at all ones once it gets there.
- R8: `wrap_flag` is set at each wrap and cleared by `wrap_clr`=1 in a clock with no wrap. If a wrap and a clear fall in the same clock, the flag stays set.
- R9: `pos_sel`=0 writes channel 0 and `pos_sel`=1 writes channel 1. The other channel's pending value is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| period_mod | input | CNT_W | Top value of the frame counter |
| width_min | input | CNT_W | Compare for the most negative position |
| width_max | input | CNT_W | Compare for position +1.0 |
| pos_wr | input | 1 | Write strobe for a position command |
| pos_sel | input | 1 | Channel written by the strobe |
| pos_val | input | POS_W | Signed position command |
| wrap_clr | input | 1 | Write-one clear of the wrap flag |
| pwm_out | output | 2 | High-true servo pulses, bit i is channel i |
| scan_start | output | 1 | One-clock pulse after each wrap |
| wrap_flag | output | 1 | Sticky wrap indication |
| frame_count | output | TICK_W | Saturating count of wraps |

## Verification
The assertions assume three things about the inputs. First, a frame lasts at least two clocks. Second, `period_mod` does not change while the counter runs. Third, `width_min` is no larger than `width_max`. The stimulus meets all three: it sets the modulus and both limits only while reset is held, and it uses a prescale divide of two. Within each configuration it sweeps every position code on both channels. It places writes at changing phases of the frame, including the wrap clock, and pulses the clear at a period that does not divide the frame length.

// File: rtl/servo_pwm_pair.sv
module servo_pwm_pair #(
  parameter int CNT_W      = 16,
  parameter int PRESC_LOG2 = 6,
  parameter int POS_W      = 12,
  parameter int TICK_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        period_mod,
  input  logic [CNT_W-1:0]        width_min,
  input  logic [CNT_W-1:0]        width_max,
  input  logic                    pos_wr,
  input  logic                    pos_sel,
  input  logic signed [POS_W-1:0] pos_val,
  input  logic                    wrap_clr,
  output logic [1:0]              pwm_out,
  output logic                    scan_start,
  output logic                    wrap_flag,
  output logic [TICK_W-1:0]       frame_count
);
  localparam int PROD_W = POS_W + CNT_W;

  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] live_q   [2];
  logic [CNT_W-1:0] shadow_q [2];

  generate
    if (PRESC_LOG2 > 0) begin : g_presc
      logic [PRESC_LOG2-1:0] presc_q;
      always_ff @(posedge clk)
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_q + PRESC_LOG2'(1);
      assign tick = &presc_q;
    end else begin : g_nopresc
      assign tick = 1'b1;
    end
  endgenerate

  assign wrap = tick && (cnt_q >= period_mod);

  logic [CNT_W-1:0]  span;
  logic [POS_W-1:0]  off_wr, off_mid;
  logic [PROD_W-1:0] prod_wr, prod_mid;
  logic [CNT_W-1:0]  cmp_wr, cmp_mid;

  assign span     = width_max - width_min;
  assign off_wr   = {~pos_val[POS_W-1], pos_val[POS_W-2:0]};
  assign off_mid  = {1'b1, {(POS_W-1){1'b0}}};
  assign prod_wr  = PROD_W'(off_wr)  * PROD_W'(span);
  assign prod_mid = PROD_W'(off_mid) * PROD_W'(span);
  assign cmp_wr   = width_min + prod_wr[PROD_W-1:POS_W];
  assign cmp_mid  = width_min + prod_mid[PROD_W-1:POS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      scan_start  <= 1'b0;
      wrap_flag   <= 1'b0;
      frame_count <= '0;
      for (int ch = 0; ch < 2; ch++) begin
        live_q[ch]   <= cmp_mid;
        shadow_q[ch] <= cmp_mid;
      end
    end else begin
      scan_start <= wrap;
      if (tick) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      if (wrap) begin
        live_q[0] <= shadow_q[0];
        live_q[1] <= shadow_q[1];
      end
      if (pos_wr) shadow_q[pos_sel] <= cmp_wr;
      if (wrap)          wrap_flag <= 1'b1;
      else if (wrap_clr) wrap_flag <= 1'b0;
      if (wrap && !(&frame_count)) frame_count <= frame_count + TICK_W'(1);
    end
  end

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_out
      assign pwm_out[ch] = cnt_q < live_q[ch];
    end
  endgenerate

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> !scan_start);
  p_start_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> cnt_q == '0);
  p_flag_after_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> wrap_flag);
  p_commit_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({live_q[1], live_q[0]}) |-> scan_start);
  p_count_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&frame_count) |=> (&frame_count));
  p_count_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_count) |-> scan_start);
endmodule

// File: tb/tb_servo_pwm_pair.sv
`timescale 1ns/1ps
module tb_servo_pwm_pair;
  localparam int P = 1, CW = 8, PW = 4, TW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [CW-1:0] period_mod = '0, width_min = '0, width_max = '0;
  logic pos_wr = 1'b0, pos_sel = 1'b0, wrap_clr = 1'b0;
  logic signed [PW-1:0] pos_val = '0;
  logic [1:0] pwm_out;
  logic scan_start, wrap_flag;
  logic [TW-1:0] frame_count;

  servo_pwm_pair #(.CNT_W(CW), .PRESC_LOG2(P), .POS_W(PW), .TICK_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .period_mod(period_mod), .width_min(width_min),
    .width_max(width_max), .pos_wr(pos_wr), .pos_sel(pos_sel), .pos_val(pos_val),
    .wrap_clr(wrap_clr), .pwm_out(pwm_out), .scan_start(scan_start),
    .wrap_flag(wrap_flag), .frame_count(frame_count));

  int checks = 0, errors = 0;
  int n, cfg_mod, cfg_min, cfg_max, m_count;
  int m_live[2], m_shadow[2], hi_acc[2];
  bit m_start, m_flag;

  function automatic int map_pos(int p);
    return cfg_min + ((p + (1 << (PW-1))) * (cfg_max - cfg_min)) / (1 << PW);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at n=%0d", tag, act, exp, n);
    end
  endtask

  task automatic do_reset(int md, int mn, int mx);
    cfg_mod = md; cfg_min = mn; cfg_max = mx;
    rst_n = 1'b0; period_mod = CW'(md); width_min = CW'(mn); width_max = CW'(mx);
    pos_wr = 1'b0; wrap_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0; m_start = 0; m_flag = 0; m_count = 0;
    for (int ch = 0; ch < 2; ch++) begin
      m_live[ch] = map_pos(0); m_shadow[ch] = map_pos(0); hi_acc[ch] = 0;
    end
    chk("R1 scan_start", int'(scan_start), 0);
    chk("R1 wrap_flag", int'(wrap_flag), 0);
    chk("R1 frame_count", int'(frame_count), 0);
    chk("R1 pwm_out", int'(pwm_out), (map_pos(0) > 0) ? 3 : 0);
  endtask

  task automatic cycle(bit wr, bit sel, int p, bit clr);
    int c;
    bit wrp;
    c = (n >> P) % (cfg_mod + 1);
    for (int ch = 0; ch < 2; ch++) begin
      chk(ch ? "R3 R5 pwm ch1" : "R3 R5 pwm ch0", int'(pwm_out[ch]), (c < m_live[ch]) ? 1 : 0);
      hi_acc[ch] += int'(pwm_out[ch]);
    end
    chk("R6 scan_start", int'(scan_start), int'(m_start));
    chk("R8 wrap_flag", int'(wrap_flag), int'(m_flag));
    chk("R7 frame_count", int'(frame_count), m_count);
    chk("R2 start at zero", (m_start && c != 0) ? 1 : 0, 0);
    pos_wr = wr; pos_sel = sel; pos_val = PW'(p); wrap_clr = clr;
    @(posedge clk);
    wrp = ((n % (1 << P)) == (1 << P) - 1) && (c == cfg_mod);
    if (wrp) begin
      for (int ch = 0; ch < 2; ch++) begin
        int e;
        e = (m_live[ch] < cfg_mod + 1) ? m_live[ch] : cfg_mod + 1;
        chk("R4 R9 R2 high time per frame", hi_acc[ch], e << P);
        hi_acc[ch] = 0;
        m_live[ch] = m_shadow[ch];
      end
    end
    if (wr) m_shadow[sel] = map_pos(p);
    m_start = wrp;
    if (wrp) m_flag = 1; else if (clr) m_flag = 0;
    if (wrp && m_count < (1 << TW) - 1) m_count++;
    n++;
    @(negedge clk);
    pos_wr = 1'b0; wrap_clr = 1'b0;
  endtask

  initial begin
    int k;
    k = 0;
    do_reset(9, 2, 8);
    chk("R4 neutral mapping", map_pos(0), 5);
    for (int p = -8; p < 8; p++) begin
      for (int sel = 0; sel < 2; sel++) begin
        cycle(1'b1, sel[0], (sel == 0) ? p : -1 - p, 1'b0);
        for (int i = 0; i < ((p + 8) * 3 + sel * 5) % 17 + 5; i++) begin
          k++;
          cycle(1'b0, 1'b0, 0, (k % 7) == 3);
        end
      end
    end
    for (int i = 0; i < 45; i++) cycle(1'b0, 1'b0, 0, 1'b0);

    do_reset(5, 0, 12);
    for (int r = 0; r < 4; r++) begin
      cycle(1'b1, 1'b0, (r % 2) ? 7 : -8, 1'b0);
      cycle(1'b1, 1'b1, (r % 2) ? -8 : 7, 1'b1);
      for (int i = 0; i < 30; i++) begin
        k++;
        cycle(1'b0, 1'b0, 0, (k % 5) == 1);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule